// File: doc/BRIEF.md
# Policy Table Switch Manager

This block decides which of a few on-chip policy table tiles the memory access monitor enforces, and it guards every change of that choice. Tiles are numbered from 0 upward in order of rising restrictiveness. After reset, tile 0 is active. A change can only move to a higher-numbered tile. Cores ask for a change over a valid/ready request channel. An external alarm line can force the most restrictive tile without any authority check.

A fixed authority mask names the core IDs that may request a change. Each request is answered one cycle after its handshake, with either an accept pulse or a reject pulse and a reason code. An accepted change does not apply at once. It waits until the monitor reports that it is idle between accesses. Then the select moves, and a restart pulse tells the monitor to begin again in state 0 of the new table.

Any tile that is neither active nor already chosen can be reloaded while the active tile keeps enforcing. A tile marked as loading cannot be switched to until its load is marked complete.

Request channel rules:
- A requester holds `req_valid`, `req_core` and `req_target` steady until `req_ready` is high at a rising edge.
- `req_ready` is low while an accepted change waits for the monitor to go idle, and in any cycle where `alarm` is high.
- The response pulses cannot be back-pressured.

Top module: `pol_switch_mgr`

## Requirements
- R1: After reset, `act_sel` is 0, every bit of `tile_ready` is 1, `req_ready` is 1, and `resp_accept`, `resp_reject` and `mon_restart` are 0.
- R2: `act_sel` never decreases. An accepted request to target j, issued while the active tile is i with no change pending, leaves `act_sel` equal to j once the change takes effect.
- R3: A request from a core whose ID is not below `N_CORES`, or whose bit in `AUTH_MASK` is 0, is rejected with reason 1 (unauthorized). This check takes priority over every other check. With the default mask 4'b0101, only cores 0 and 2 are authorized.
- R4: An authorized request whose target is not greater than the current level is rejected with reason 2 (not more restrictive). The current level is the pending target if a change is pending, and the active tile otherwise.
- R5: An authorized request to a higher target whose `tile_ready` bit is 0 is rejected with reason 3 (load incomplete).
- R6: One cycle after each request handshake, exactly one of `resp_accept` and `resp_reject` pulses for one cycle. `resp_reason` is 0 with an accept.
- R7: An accepted change updates `act_sel` at the first rising edge at which `mon_idle` is high, starting with the edge after the accept. `mon_restart` is high for exactly that one cycle in which the new `act_sel` first appears.
- R8: While a change is pending, `req_ready` is 0. A held request is neither answered nor acted on until the change has taken effect, and is then handled normally.
- R9: `load_start` clears `tile_ready[load_tile]` and `load_done` sets it. A `load_start` aimed at the active tile or the pending target is ignored.
- R10: A high `alarm` sets up a change to tile `N_POL-1` with no authority check and no response pulse. This happens only if that tile is ready and above the current level; otherwise the alarm has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Switch request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_core | input | ID_W | ID of the requesting core |
| req_target | input | IDX_W | Requested tile index |
| resp_accept | output | 1 | Request accepted (one-cycle pulse) |
| resp_reject | output | 1 | Request rejected (one-cycle pulse) |
| resp_reason | output | 2 | 0 none, 1 unauthorized, 2 not more restrictive, 3 load incomplete |
| alarm | input | 1 | External attack indication |
| mon_idle | input | 1 | Monitor is between accesses |
| act_sel | output | IDX_W | Active tile select |
| mon_restart | output | 1 | Monitor restarts in state 0 of the new tile |
| load_start | input | 1 | Mark `load_tile` as loading |
| load_done | input | 1 | Mark `load_tile` as loaded |
| load_tile | input | IDX_W | Tile addressed by the load markers |
| tile_ready | output | N_POL | Per-tile load-complete flags |

## Verification
The following properties are checked on every cycle:
- `act_sel` never moves backwards.
- It holds still unless the monitor was idle during a pending change.
- A restart pulse always comes with a real change of select.
- The active tile is always marked loaded.
- The two response pulses never overlap.
- An accept always leaves a change pending.
- An alarm cycle produces no response.
- An unauthorized request always draws reason 1.

Some behaviour needs the bench's scenarios:
- The exact priority among the three reasons.
- The final select value.
- The hold of a back-pressured request across a long non-idle stretch.
- Whether an alarm is ignored or taken, depending on the load state.

The bench covers these by sweeping every core ID, starting level, target and load state.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [1:0] {
    RSN_NONE      = 2'd0,
    RSN_UNAUTH    = 2'd1,
    RSN_ORDER     = 2'd2,
    RSN_NOTLOADED = 2'd3
  } reason_e;
endpackage

// File: rtl/psw_judge.sv
module psw_judge
  import psw_pkg::*;
#(
  parameter int N_POL   = 4,
  parameter int N_CORES = 4,
  parameter int ID_W    = 3,
  parameter logic [N_CORES-1:0] AUTH_MASK = 4'b0101,
  localparam int IDX_W  = (N_POL > 1) ? $clog2(N_POL) : 1
) (
  input  logic [ID_W-1:0]  core,
  input  logic [IDX_W-1:0] tgt,
  input  logic [IDX_W-1:0] level,
  input  logic [N_POL-1:0] ready,
  output logic             authorized,
  output reason_e          reason
);
  logic [N_CORES-1:0] hit;
  logic [N_POL-1:0]   tsel;
  logic               tgt_ready;

  for (genvar c = 0; c < N_CORES; c++) begin : g_auth
    assign hit[c] = AUTH_MASK[c] && (core == ID_W'(c));
  end

  for (genvar t = 0; t < N_POL; t++) begin : g_tsel
    assign tsel[t] = (tgt == IDX_W'(t));
  end

  assign authorized = |hit;
  assign tgt_ready  = |(tsel & ready);

  always_comb begin
    if (!authorized)     reason = RSN_UNAUTH;
    else if (tgt <= level) reason = RSN_ORDER;
    else if (!tgt_ready) reason = RSN_NOTLOADED;
    else                 reason = RSN_NONE;
  end
endmodule

// File: rtl/psw_tiles.sv
module psw_tiles #(
  parameter int N_POL = 4,
  localparam int IDX_W = (N_POL > 1) ? $clog2(N_POL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_start,
  input  logic             load_done,
  input  logic [IDX_W-1:0] load_tile,
  input  logic [N_POL-1:0] guard,
  input  logic [N_POL-1:0] act_oh,
  output logic [N_POL-1:0] ready
);
  for (genvar t = 0; t < N_POL; t++) begin : g_tile
    logic ready_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ready_q <= 1'b1;
      end else if (load_tile == IDX_W'(t)) begin
        if (load_start && !guard[t]) ready_q <= 1'b0;
        else if (load_done)          ready_q <= 1'b1;
      end
    end
    assign ready[t] = ready_q;
  end

  // R9: the tile being enforced is always fully loaded
  assert_active_loaded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready & act_oh) != '0);
endmodule

// File: rtl/psw_commit.sv
module psw_commit #(
  parameter int N_POL = 4,
  localparam int IDX_W = (N_POL > 1) ? $clog2(N_POL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic [IDX_W-1:0] new_tgt,
  input  logic             mon_idle,
  output logic [IDX_W-1:0] act,
  output logic             pending,
  output logic [IDX_W-1:0] pend_tgt,
  output logic             restart
);
  logic apply;
  assign apply = pending && mon_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act      <= '0;
      pending  <= 1'b0;
      pend_tgt <= '0;
      restart  <= 1'b0;
    end else begin
      restart <= apply;
      if (apply) act <= pend_tgt;
      if (set) begin
        pending  <= 1'b1;
        pend_tgt <= new_tgt;
      end else if (apply) begin
        pending <= 1'b0;
      end
    end
  end

  assert_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> act >= $past(act));
  assert_idle_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pending && mon_idle) |=> $stable(act));
  assert_restart_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> act != $past(act));
endmodule

// File: rtl/pol_switch_mgr.sv
module pol_switch_mgr
  import psw_pkg::*;
#(
  parameter int N_POL   = 4,
  parameter int N_CORES = 4,
  parameter int ID_W    = 3,
  parameter logic [N_CORES-1:0] AUTH_MASK = 4'b0101,
  localparam int IDX_W  = (N_POL > 1) ? $clog2(N_POL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ID_W-1:0]  req_core,
  input  logic [IDX_W-1:0] req_target,
  output logic             resp_accept,
  output logic             resp_reject,
  output logic [1:0]       resp_reason,
  input  logic             alarm,
  input  logic             mon_idle,
  output logic [IDX_W-1:0] act_sel,
  output logic             mon_restart,
  input  logic             load_start,
  input  logic             load_done,
  input  logic [IDX_W-1:0] load_tile,
  output logic [N_POL-1:0] tile_ready
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_POL - 1);

  logic             pending, authorized, fire, take_req, alarm_take, set;
  logic [IDX_W-1:0] pend_tgt, level, new_tgt;
  logic [N_POL-1:0] act_oh, pend_oh, new_oh, guard;
  reason_e          reason;

  assign level      = pending ? pend_tgt : act_sel;
  assign alarm_take = alarm && (level != TOP_IDX) && tile_ready[N_POL-1];
  assign req_ready  = !pending && !alarm;
  assign fire       = req_valid && req_ready;
  assign take_req   = fire && (reason == RSN_NONE);
  assign set        = alarm_take || take_req;
  assign new_tgt    = alarm_take ? TOP_IDX : req_target;

  for (genvar t = 0; t < N_POL; t++) begin : g_oh
    assign act_oh[t]  = (act_sel == IDX_W'(t));
    assign pend_oh[t] = pending && (pend_tgt == IDX_W'(t));
    assign new_oh[t]  = set && (new_tgt == IDX_W'(t));
  end
  assign guard = act_oh | pend_oh | new_oh;

  psw_judge #(.N_POL(N_POL), .N_CORES(N_CORES), .ID_W(ID_W), .AUTH_MASK(AUTH_MASK)) judge_i (
    .core(req_core), .tgt(req_target), .level(level), .ready(tile_ready),
    .authorized(authorized), .reason(reason)
  );

  psw_tiles #(.N_POL(N_POL)) tiles_i (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .load_done(load_done),
    .load_tile(load_tile), .guard(guard), .act_oh(act_oh), .ready(tile_ready)
  );

  psw_commit #(.N_POL(N_POL)) commit_i (
    .clk(clk), .rst_n(rst_n), .set(set), .new_tgt(new_tgt), .mon_idle(mon_idle),
    .act(act_sel), .pending(pending), .pend_tgt(pend_tgt), .restart(mon_restart)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_accept <= 1'b0;
      resp_reject <= 1'b0;
      resp_reason <= 2'd0;
    end else begin
      resp_accept <= fire && (reason == RSN_NONE);
      resp_reject <= fire && (reason != RSN_NONE);
      resp_reason <= fire ? reason : RSN_NONE;
    end
  end

  assert_resp_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_accept && resp_reject));
  assert_accept_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_accept |-> pending);
  assert_unauth_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !authorized) |=> (resp_reject && resp_reason == RSN_UNAUTH));
  assert_alarm_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarm |=> (!resp_accept && !resp_reject));
endmodule

// File: tb/pol_switch_mgr_tb_top.sv
module pol_switch_mgr_tb_top;
  localparam int N_POL = 4, N_CORES = 4, ID_W = 3, IDX_W = 2;
  localparam logic [3:0] MASK = 4'b0101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, alarm = 0, mon_idle = 1, load_start = 0, load_done = 0;
  logic [ID_W-1:0]  req_core = '0;
  logic [IDX_W-1:0] req_target = '0, load_tile = '0;
  logic req_ready, resp_accept, resp_reject, mon_restart;
  logic [1:0] resp_reason;
  logic [IDX_W-1:0] act_sel;
  logic [N_POL-1:0] tile_ready;

  int n_chk = 0, n_bad = 0;
  logic r_acc, r_rej;
  logic [1:0] r_rsn;

  always #4 clk = ~clk;

  pol_switch_mgr #(.N_POL(N_POL), .N_CORES(N_CORES), .ID_W(ID_W), .AUTH_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_target(req_target), .resp_accept(resp_accept),
    .resp_reject(resp_reject), .resp_reason(resp_reason), .alarm(alarm),
    .mon_idle(mon_idle), .act_sel(act_sel), .mon_restart(mon_restart),
    .load_start(load_start), .load_done(load_done), .load_tile(load_tile),
    .tile_ready(tile_ready)
  );

  task automatic chk(input bit ok, input string tag, input int actual, input int expected);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; alarm = 0; mon_idle = 1; load_start = 0; load_done = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  // handshake a request; capture the response one edge later
  task automatic do_req(input int core, input int tgt);
    @(negedge clk);
    req_valid = 1; req_core = ID_W'(core); req_target = IDX_W'(tgt);
    @(posedge clk); #1;
    r_acc = resp_accept; r_rej = resp_reject; r_rsn = resp_reason;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic load_mark(input int tile, input bit start);
    @(negedge clk);
    load_tile = IDX_W'(tile); load_start = start; load_done = !start;
    @(negedge clk);
    load_start = 0; load_done = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R1 reset state
    chk(act_sel == 0, "R1 act_sel", act_sel, 0);
    chk(tile_ready == 4'hF, "R1 tile_ready", tile_ready, 15);
    chk(req_ready == 1, "R1 req_ready", req_ready, 1);
    chk(!resp_accept && !resp_reject && !mon_restart, "R1 pulses",
        {resp_accept, resp_reject, mon_restart}, 0);

    // exhaustive sweep: core x starting level x target x load state
    for (int core = 0; core < 8; core++)
      for (int lvl = 0; lvl < N_POL; lvl++)
        for (int tgt = 0; tgt < N_POL; tgt++)
          for (int inc = 0; inc < 2; inc++) begin
            bit auth, rdy;
            int exp_rsn, exp_act;
            do_reset();
            if (lvl > 0) begin
              do_req(0, lvl);
              @(posedge clk); #1;
              chk(act_sel == lvl, "R2 setup level", act_sel, lvl);
            end
            rdy = 1;
            if (inc == 1) begin
              load_mark(tgt, 1);
              rdy = (tgt == lvl);
              #1;
              chk(tile_ready[tgt] == rdy, "R9 load_start guard", tile_ready[tgt], rdy);
            end
            auth = (core < N_CORES) && MASK[core];
            if (!auth) exp_rsn = 1;
            else if (tgt <= lvl) exp_rsn = 2;
            else if (!rdy) exp_rsn = 3;
            else exp_rsn = 0;
            do_req(core, tgt);
            chk(r_acc == (exp_rsn == 0) && r_rej == (exp_rsn != 0), "R6 one pulse",
                {r_acc, r_rej}, (exp_rsn == 0) ? 2 : 1);
            case (exp_rsn)
              1: chk(r_rsn == 1, "R3 unauthorized", r_rsn, 1);
              2: chk(r_rsn == 2, "R4 not more restrictive", r_rsn, 2);
              3: chk(r_rsn == 3, "R5 load incomplete", r_rsn, 3);
              default: chk(r_rsn == 0, "R6 accept reason", r_rsn, 0);
            endcase
            @(posedge clk); #1;
            exp_act = (exp_rsn == 0) ? tgt : lvl;
            chk(act_sel == exp_act, "R2 final select", act_sel, exp_act);
            chk(mon_restart == (exp_rsn == 0), "R7 restart pulse", mon_restart, exp_rsn == 0);
            @(posedge clk); #1;
            chk(mon_restart == 0, "R7 restart one cycle", mon_restart, 0);
          end

    // R7/R8: non-idle monitor holds the change; held request waits
    do_reset();
    @(negedge clk); mon_idle = 0;
    do_req(2, 2);
    chk(r_acc == 1, "R7 accept while busy", r_acc, 1);
    @(negedge clk);
    req_valid = 1; req_core = 0; req_target = 3;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      chk(req_ready == 0, "R8 back-pressure", req_ready, 0);
      chk(act_sel == 0, "R7 select held", act_sel, 0);
      chk(!resp_accept && !resp_reject, "R8 no answer", {resp_accept, resp_reject}, 0);
    end
    @(negedge clk); mon_idle = 1;
    @(posedge clk); #1;
    chk(act_sel == 2 && mon_restart == 1, "R7 apply on idle", act_sel, 2);
    @(posedge clk); #1;
    chk(resp_accept == 1, "R8 held request answered", resp_accept, 1);
    @(negedge clk); req_valid = 0;
    @(posedge clk); #1;
    chk(act_sel == 3, "R8 held request applied", act_sel, 3);

    // R10: alarm forces top tile, no response
    do_reset();
    @(negedge clk); alarm = 1;
    @(posedge clk); #1;
    chk(!resp_accept && !resp_reject, "R10 alarm silent", {resp_accept, resp_reject}, 0);
    @(negedge clk); alarm = 0;
    @(posedge clk); #1;
    chk(act_sel == 3, "R10 alarm switch", act_sel, 3);

    // R10: alarm ignored when top tile not loaded; R9 load_done restores
    do_reset();
    load_mark(3, 1);
    @(negedge clk); alarm = 1;
    @(negedge clk); alarm = 0;
    repeat (3) @(posedge clk); #1;
    chk(act_sel == 0 && mon_restart == 0, "R10 alarm ignored", act_sel, 0);
    load_mark(3, 0); #1;
    chk(tile_ready[3] == 1, "R9 load_done", tile_ready[3], 1);
    @(negedge clk); alarm = 1;
    @(negedge clk); alarm = 0;
    repeat (2) @(posedge clk); #1;
    chk(act_sel == 3, "R10 alarm after load", act_sel, 3);
    @(negedge clk); alarm = 1;
    @(negedge clk); alarm = 0;
    repeat (2) @(posedge clk); #1;
    chk(act_sel == 3 && mon_restart == 0, "R10 alarm at top ignored", act_sel, 3);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule